// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block fronts a fixed-size window of host memory and fans every access out to one of several downstream host-bridge ports. A requester supplies an offset within the window, a byte count, a read/write flag and write data. The router adds the configured window base to the offset to form the host physical address. It divides that address by the interleave granule and takes the quotient modulo the number of active ways, which gives the destination port. It then strobes that port with the address, size and data.

Accesses that cannot be delivered still complete. This covers a rejected configuration, an offset past the window end, a bad byte count and a port that is not ready. Such a read returns all-zero data with the poison flag raised. Such a write is dropped and completes without error. Requests are accepted every cycle, and each one produces exactly one response.

Top module: `ilv_window_router`

## Requirements
- R1: `cfgBad` is high whenever `cfgSize` is zero or has any of bits [27:0] set (the window must be a whole multiple of 256 MiB).
- R2: `cfgBad` is high whenever `cfgWays` is not one of 1, 2, 3, 4, 6, 8 (and not above PORTS), or the effective granule code is above 6. While `cfgBad` is high, no port is strobed and every access takes the unroutable response.
- R3: The address driven on `portAddr` is `cfgBase + reqOffset`, taken modulo 2^ADDR_W.
- R4: The destination port is `(addr >> (8 + g)) mod cfgWays`, where addr is the address of R3 and g is the effective granule code. At most one bit of `portReqValid` is high, and it is the bit of that port.
- R5: When `cfgGranSet` is 0, the code on `cfgGranCode` is ignored and g is taken as 0 (256-byte granule).
- R6: An unroutable read responds with `rspErr` = 1 and `rspRdata` = 0.
- R7: An unroutable write strobes no port and responds with `rspErr` = 0. A write never reports an error.
- R8: A request whose `reqOffset` is not below `cfgSize` is unroutable.
- R9: A request whose `reqSize` is outside 1..8 is unroutable. For a routed access, `portSize`, `portWrite` and `portWdata` carry the request's values unchanged.
- R10: A routed read returns the selected port's 64-bit little-endian data with byte lanes numbered `reqSize` and above forced to zero (lane b is bits 8b+7..8b).
- R11: A request whose destination port has `portReady` low is unroutable.
- R12: `portReqValid` is raised one cycle after the request cycle. `rspValid` is high for exactly one cycle, two cycles after the request cycle. Back-to-back requests give back-to-back responses in order. After reset both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgBase | input | ADDR_W | Host physical base of the window |
| cfgSize | input | ADDR_W | Window size in bytes |
| cfgWays | input | $clog2(PORTS+1) | Number of interleave targets |
| cfgGranCode | input | 3 | Granule code g, granule = 256 << g bytes |
| cfgGranSet | input | 1 | Granule code supplied; when low g = 0 |
| cfgBad | output | 1 | Configuration rejected |
| reqValid | input | 1 | Request present this cycle |
| reqOffset | input | ADDR_W | Offset inside the window |
| reqSize | input | 4 | Access size in bytes |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 64 | Write data, little-endian |
| rspValid | output | 1 | Response present |
| rspErr | output | 1 | Poisoned read response |
| rspRdata | output | 64 | Read data |
| portReqValid | output | PORTS | One-hot port strobe |
| portAddr | output | ADDR_W | Host physical address to the port |
| portSize | output | 4 | Access size to the port |
| portWrite | output | 1 | Direction to the port |
| portWdata | output | 64 | Write data to the port |
| portReady | input | PORTS | Port present and ready |
| portRdata | input | PORTS*64 | Per-port read data, same cycle as strobe |

## Verification
The bench builds the router with PORTS = 8 and ADDR_W = 40. Eight ports make every legal way count reachable, including the non-power-of-two counts 3 and 6, where the picker must fold in a mod-3 residue. They also make 5, 7 and 0 available as illegal counts. A 40-bit address allows a base with low-order bits set and a 1 GiB window, so the base addition visibly moves the interleave decode across granules at granule codes 0, 2 and 6.

// File: rtl/wr_pkg.sv
package wr_pkg;
  localparam int LANES     = 8;
  localparam int DATA_W    = LANES * 8;
  localparam int GRAN_BASE = 8;
  localparam int GRAN_MAX  = 6;
  localparam int SIZE_W    = 4;
  localparam int ALIGN_LOG = 28;

  typedef struct packed {
    logic capture;   // load the request into the stage
    logic present;   // stage holds a live request, update the response
    logic passData;  // routed read: forward the masked port data
  } rtrStrobe_t;
endpackage

// File: rtl/wr_port_pick.sv
module wr_port_pick #(
  parameter int QW    = 40,
  parameter int PORTS = 8,
  localparam int PORT_W = $clog2(PORTS),
  localparam int WAYS_W = $clog2(PORTS + 1)
) (
  input  logic [QW-1:0]     quot,
  input  logic [WAYS_W-1:0] ways,
  output logic [PORT_W-1:0] idx
);
  function automatic logic [1:0] modThree(input logic [QW-1:0] x);
    logic [1:0] r;
    r = 2'd0;
    for (int i = QW - 1; i >= 0; i--) begin
      case ({r, x[i]})
        3'b001: r = 2'd1;
        3'b010: r = 2'd2;
        3'b100: r = 2'd1;
        3'b101: r = 2'd2;
        default: r = 2'd0;
      endcase
    end
    return r;
  endfunction

  logic [QW-1:0] acc;
  logic [QW-1:0] lowMask;

  always_comb begin
    acc     = '0;
    lowMask = '0;
    for (int k = 0; k <= PORT_W; k++) begin
      lowMask = (QW'(1) << k) - QW'(1);
      if (int'(ways) == (1 << k)) begin
        acc = quot & lowMask;
      end else if (int'(ways) == (3 << k)) begin
        acc = (QW'(modThree(quot >> k)) << k) | (quot & lowMask);
      end
    end
    idx = acc[PORT_W-1:0];
  end
endmodule

// File: rtl/wr_path.sv
module wr_path
  import wr_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PORTS  = 8,
  localparam int PORT_W = $clog2(PORTS),
  localparam int WAYS_W = $clog2(PORTS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rtrStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       cfgBase,
  input  logic [ADDR_W-1:0]       cfgSize,
  input  logic [2:0]              granCode,
  input  logic [WAYS_W-1:0]       ways,
  input  logic [ADDR_W-1:0]       reqOffset,
  input  logic [SIZE_W-1:0]       reqSize,
  input  logic                    reqWrite,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [PORTS*DATA_W-1:0] portRdata,
  output logic [PORT_W-1:0]       stgIdx,
  output logic                    stgInRange,
  output logic                    stgSizeOk,
  output logic                    stgWrite,
  output logic [ADDR_W-1:0]       portAddr,
  output logic [SIZE_W-1:0]       portSize,
  output logic [DATA_W-1:0]       portWdata,
  output logic [DATA_W-1:0]       rspRdata
);
  logic [ADDR_W-1:0] stgAddr;
  logic [SIZE_W-1:0] stgSize;
  logic [DATA_W-1:0] stgWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgAddr    <= '0;
      stgSize    <= '0;
      stgWdata   <= '0;
      stgWrite   <= 1'b0;
      stgInRange <= 1'b0;
      stgSizeOk  <= 1'b0;
    end else if (strobe.capture) begin
      stgAddr    <= cfgBase + reqOffset;
      stgSize    <= reqSize;
      stgWdata   <= reqWdata;
      stgWrite   <= reqWrite;
      stgInRange <= reqOffset < cfgSize;
      stgSizeOk  <= (reqSize != '0) && (reqSize <= SIZE_W'(LANES));
    end
  end

  logic [3:0]        shAmt;
  logic [ADDR_W-1:0] quot;
  assign shAmt = 4'(GRAN_BASE) + {1'b0, granCode};
  assign quot  = stgAddr >> shAmt;

  wr_port_pick #(.QW(ADDR_W), .PORTS(PORTS)) u_pick (
    .quot(quot),
    .ways(ways),
    .idx (stgIdx)
  );

  logic [DATA_W-1:0] selRd;
  logic [DATA_W-1:0] maskedRd;
  assign selRd = portRdata[stgIdx*DATA_W +: DATA_W];

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      maskedRd[b*8 +: 8] = (SIZE_W'(b) < stgSize) ? selRd[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (strobe.present) begin
      rspRdata <= strobe.passData ? maskedRd : '0;
    end
  end

  assign portAddr  = stgAddr;
  assign portSize  = stgSize;
  assign portWdata = stgWdata;
endmodule

// File: rtl/wr_ctrl.sv
module wr_ctrl
  import wr_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PORTS  = 8,
  localparam int PORT_W = $clog2(PORTS),
  localparam int WAYS_W = $clog2(PORTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [WAYS_W-1:0] cfgWays,
  input  logic [2:0]        cfgGranCode,
  input  logic              cfgGranSet,
  input  logic [PORTS-1:0]  portReady,
  input  logic [PORT_W-1:0] stgIdx,
  input  logic              stgInRange,
  input  logic              stgSizeOk,
  input  logic              stgWrite,
  output logic [2:0]        effGran,
  output rtrStrobe_t        strobe,
  output logic              cfgBad,
  output logic [PORTS-1:0]  portReqValid,
  output logic              rspValid,
  output logic              rspErr
);
  function automatic logic waysLegal(input logic [WAYS_W-1:0] w);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k <= PORT_W; k++) begin
      if ((int'(w) == (1 << k)) && ((1 << k) <= PORTS)) ok = 1'b1;
      if ((int'(w) == (3 << k)) && ((3 << k) <= PORTS)) ok = 1'b1;
    end
    return ok;
  endfunction

  logic sizeAligned;
  logic cfgOk;
  logic stgValid;
  logic route;

  assign effGran     = cfgGranSet ? cfgGranCode : 3'd0;
  assign sizeAligned = (cfgSize[ALIGN_LOG-1:0] == '0) && (cfgSize != '0);
  assign cfgOk       = sizeAligned && waysLegal(cfgWays) && (int'(effGran) <= GRAN_MAX);
  assign cfgBad      = !cfgOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      stgValid <= reqValid;
      rspValid <= stgValid;
      rspErr   <= stgValid && !route && !stgWrite;
    end
  end

  assign route = stgValid && cfgOk && stgInRange && stgSizeOk && portReady[stgIdx];

  for (genvar p = 0; p < PORTS; p++) begin : g_strobe
    assign portReqValid[p] = route && (stgIdx == PORT_W'(p));
  end

  assign strobe.capture  = reqValid;
  assign strobe.present  = stgValid;
  assign strobe.passData = route && !stgWrite;

  a_r4_single_port: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portReqValid));

  a_r12_rsp_two_later: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ##2 rspValid);

  a_r11_ready_only: assert property (@(posedge clk) disable iff (!rstN)
    (|portReqValid) |-> (|(portReqValid & portReady)));

  a_r2_bad_silent: assert property (@(posedge clk) disable iff (!rstN)
    cfgBad |-> (portReqValid == '0));
endmodule

// File: rtl/ilv_window_router.sv
module ilv_window_router
  import wr_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PORTS  = 8,
  localparam int PORT_W = $clog2(PORTS),
  localparam int WAYS_W = $clog2(PORTS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cfgBase,
  input  logic [ADDR_W-1:0]       cfgSize,
  input  logic [WAYS_W-1:0]       cfgWays,
  input  logic [2:0]              cfgGranCode,
  input  logic                    cfgGranSet,
  output logic                    cfgBad,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqOffset,
  input  logic [SIZE_W-1:0]       reqSize,
  input  logic                    reqWrite,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    rspValid,
  output logic                    rspErr,
  output logic [DATA_W-1:0]       rspRdata,
  output logic [PORTS-1:0]        portReqValid,
  output logic [ADDR_W-1:0]       portAddr,
  output logic [SIZE_W-1:0]       portSize,
  output logic                    portWrite,
  output logic [DATA_W-1:0]       portWdata,
  input  logic [PORTS-1:0]        portReady,
  input  logic [PORTS*DATA_W-1:0] portRdata
);
  rtrStrobe_t        strobe;
  logic [PORT_W-1:0] stgIdx;
  logic              stgInRange;
  logic              stgSizeOk;
  logic              stgWrite;
  logic [2:0]        effGran;

  wr_ctrl #(.ADDR_W(ADDR_W), .PORTS(PORTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgSize(cfgSize), .cfgWays(cfgWays), .cfgGranCode(cfgGranCode),
    .cfgGranSet(cfgGranSet), .portReady(portReady),
    .stgIdx(stgIdx), .stgInRange(stgInRange), .stgSizeOk(stgSizeOk),
    .stgWrite(stgWrite), .effGran(effGran), .strobe(strobe),
    .cfgBad(cfgBad), .portReqValid(portReqValid),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  wr_path #(.ADDR_W(ADDR_W), .PORTS(PORTS)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgBase(cfgBase), .cfgSize(cfgSize), .granCode(effGran), .ways(cfgWays),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .portRdata(portRdata),
    .stgIdx(stgIdx), .stgInRange(stgInRange), .stgSizeOk(stgSizeOk),
    .stgWrite(stgWrite), .portAddr(portAddr), .portSize(portSize),
    .portWdata(portWdata), .rspRdata(rspRdata)
  );

  assign portWrite = stgWrite;

  a_r6_poison_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == '0));

  a_r7_write_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> ##2 (rspValid && !rspErr));
endmodule

// File: tb/sim_ilv_window_router.sv
module sim_ilv_window_router;
  localparam int AW = 40;
  localparam int NP = 8;
  localparam int WW = $clog2(NP + 1);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [AW-1:0]  cfgBase = '0;
  logic [AW-1:0]  cfgSize = '0;
  logic [WW-1:0]  cfgWays = '0;
  logic [2:0]     cfgGranCode = '0;
  logic           cfgGranSet = 1'b0;
  logic           cfgBad;
  logic           reqValid = 1'b0;
  logic [AW-1:0]  reqOffset = '0;
  logic [3:0]     reqSize = '0;
  logic           reqWrite = 1'b0;
  logic [63:0]    reqWdata = '0;
  logic           rspValid;
  logic           rspErr;
  logic [63:0]    rspRdata;
  logic [NP-1:0]  portReqValid;
  logic [AW-1:0]  portAddr;
  logic [3:0]     portSize;
  logic           portWrite;
  logic [63:0]    portWdata;
  logic [NP-1:0]  portReady = '1;
  logic [NP*64-1:0] portRdata;

  always #5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) portRdata[p*64 +: 64] = {8'(8'h10 + p), 16'hBEEF, portAddr};
  end

  ilv_window_router #(.ADDR_W(AW), .PORTS(NP)) u0 (.*);

  typedef struct {
    logic [NP-1:0] vec;
    logic [AW-1:0] addr;
    logic          err;
    logic [63:0]   data;
    logic          wr;
    logic [63:0]   wdata;
    logic [3:0]    size;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit cfgOkModel();
    int g;
    g = cfgGranSet ? int'(cfgGranCode) : 0;
    return (cfgSize % (AW'(1) << 28) == 0) && (cfgSize != 0) && (g <= 6) &&
           (cfgWays inside {1, 2, 3, 4, 6, 8});
  endfunction

  task automatic send(input logic [AW-1:0] off, input logic [3:0] sz,
                      input logic wr, input logic [63:0] wd, input string tag);
    exp_t e;
    logic [AW-1:0] hpa;
    int g;
    int idx;
    bit route;
    hpa = cfgBase + off;
    g = cfgGranSet ? int'(cfgGranCode) : 0;
    idx = (cfgWays == 0) ? 0 : int'((hpa >> (8 + g)) % AW'(cfgWays));
    route = cfgOkModel() && (off < cfgSize) && (sz >= 1) && (sz <= 8) && portReady[idx % NP];
    e.vec = route ? NP'(1) << idx : '0;
    e.addr = hpa;
    e.err = !route && !wr;
    e.data = '0;
    if (route && !wr) begin
      e.data = {8'(8'h10 + idx), 16'hBEEF, hpa};
      for (int b = 0; b < 8; b++) if (b >= int'(sz)) e.data[b*8 +: 8] = 8'h00;
    end
    e.wr = wr; e.wdata = wd; e.size = sz; e.tag = tag;
    sb.push_back(e);
    reqValid = 1'b1; reqOffset = off; reqSize = sz; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: port strobe seen one cycle before the response it belongs to
  logic [NP-1:0] prevVec = '0;
  logic [AW-1:0] prevAddr = '0;
  logic [3:0]    prevSize = '0;
  logic          prevWrite = 1'b0;
  logic [63:0]   prevWdata = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R12", "response without request", 64'(rspValid), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(prevVec == e.vec, e.tag, "R4 port strobe", 64'(prevVec), 64'(e.vec));
          if (e.vec != 0) begin
            check(prevAddr == e.addr, "R3", "port address", 64'(prevAddr), 64'(e.addr));
            check(prevSize == e.size && prevWrite == e.wr, "R9", "size/dir",
                  64'({prevWrite, prevSize}), 64'({e.wr, e.size}));
            if (e.wr) check(prevWdata == e.wdata, "R9", "write data", prevWdata, e.wdata);
          end
          check(rspErr == e.err, e.tag, "R6/R7 err flag", 64'(rspErr), 64'(e.err));
          check(rspRdata == e.data, e.tag, "R10 read data", rspRdata, e.data);
        end
      end
      prevVec = portReqValid; prevAddr = portAddr; prevSize = portSize;
      prevWrite = portWrite; prevWdata = portWdata;
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R12", "watchdog expired", 64'(sb.size()), 64'd0);
    finishRun();
  end

  initial begin
    idle(2);
    check(rspValid == 0 && portReqValid == 0, "R12", "reset state",
          64'({rspValid, portReqValid}), 64'd0);
    rstN = 1'b1;
    idle(1);

    // Main configuration: base with low bits set, 1 GiB, 8 ways, 1 KiB granule
    cfgBase = 40'h10_0000_0300; cfgSize = 40'h00_4000_0000;
    cfgWays = 8; cfgGranCode = 3'd2; cfgGranSet = 1'b1;
    idle(1);
    check(cfgBad == 0, "R1", "legal cfg accepted", 64'(cfgBad), 64'd0);
    for (int i = 0; i < 9; i++) send(40'(i) * 40'h400 + 40'h10, 4'd8, 1'b0, '0, "R4");
    send(40'h0000_1234, 4'd3, 1'b0, '0, "R10");
    send(40'h0000_2001, 4'd1, 1'b0, '0, "R10");
    send(40'h0000_0C00, 4'd5, 1'b1, 64'h0123_4567_89AB_CDEF, "R9");
    send(40'h3FFF_FFF8, 4'd8, 1'b0, '0, "R8");
    send(40'h4000_0000, 4'd4, 1'b0, '0, "R8");
    send(40'h4000_0000, 4'd4, 1'b1, 64'h55, "R7");
    send(40'h0000_0100, 4'd0, 1'b0, '0, "R9");
    send(40'h0000_0100, 4'd9, 1'b0, '0, "R9");
    send(40'h0000_0100, 4'd9, 1'b1, 64'h77, "R7");
    idle(3);

    // Port 2 absent
    portReady = 8'hFB;
    send(40'h0000_0800, 4'd8, 1'b0, '0, "R11");
    send(40'h0000_0800, 4'd8, 1'b1, 64'h99, "R11");
    send(40'h0000_0400, 4'd8, 1'b0, '0, "R11");
    idle(3);
    portReady = '1;

    // Three ways, granule code ignored
    cfgWays = 3; cfgGranCode = 3'd5; cfgGranSet = 1'b0;
    idle(1);
    check(cfgBad == 0, "R5", "ignored code accepted", 64'(cfgBad), 64'd0);
    for (int i = 0; i < 7; i++) send(40'(i) * 40'h100 + 40'h2_0000, 4'd4, 1'b0, '0, "R5");
    send(40'h0000_0500, 4'd2, 1'b1, 64'hAAAA, "R4");
    idle(3);

    // Six ways, 16 KiB granule, back-to-back burst
    cfgWays = 6; cfgGranCode = 3'd6; cfgGranSet = 1'b1;
    idle(1);
    for (int i = 0; i < 8; i++) send(40'(i) * 40'h4000 + 40'h0123_0000, 4'd8, i[0], 64'(i), "R12");
    idle(3);

    // Illegal configurations
    cfgSize = 40'h00_4000_1000;
    idle(1);
    check(cfgBad == 1, "R1", "unaligned size", 64'(cfgBad), 64'd1);
    send(40'h0, 4'd8, 1'b0, '0, "R1");
    idle(3);
    cfgSize = '0;
    idle(1);
    check(cfgBad == 1, "R1", "zero size", 64'(cfgBad), 64'd1);
    cfgSize = 40'h00_4000_0000; cfgWays = 5;
    idle(1);
    check(cfgBad == 1, "R2", "five ways", 64'(cfgBad), 64'd1);
    send(40'h0, 4'd8, 1'b0, '0, "R2");
    send(40'h0, 4'd8, 1'b1, 64'h1, "R2");
    idle(3);
    cfgWays = 0;
    idle(1);
    check(cfgBad == 1, "R2", "zero ways", 64'(cfgBad), 64'd1);
    cfgWays = 4; cfgGranCode = 3'd7;
    idle(1);
    check(cfgBad == 1, "R2", "granule code 7", 64'(cfgBad), 64'd1);
    cfgGranSet = 1'b0;
    idle(1);
    check(cfgBad == 0, "R5", "code 7 ignored when unset", 64'(cfgBad), 64'd0);
    send(40'h0000_0300, 4'd6, 1'b0, '0, "R5");
    idle(4);

    check(sb.size() == 0, "R12", "all responses seen", 64'(sb.size()), 64'd0);
    finishRun();
  end
endmodule